// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front-End

This block is the bus-facing half of a byte-addressed serial memory. It watches a two-wire bus (a clock line and a bidirectional open-drain data line), recognises start and stop conditions, and checks the first byte of every transfer against a fixed 4-bit device code and three strap pins. It answers that byte with an acknowledge. A write transfer then delivers a two-byte word address and any number of data bytes. A read transfer streams bytes back from the memory. The block never drives the data line high: it only asserts an output enable that pulls the line low.

On a write, each received data byte leaves the block as a one-cycle strobe with its data and target address. A further strobe at the closing stop condition tells the storage side to start its internal write cycle. While the storage side reports busy, the block refuses to acknowledge new transfers. On a read, the block issues a one-cycle request with an address to a synchronous memory port, whose data arrive two clock edges later. It shifts that byte out most significant bit first and keeps going for as long as the master acknowledges.

Top module: `tws_mem_slave`

## Requirements
- R1: After a start condition (data falling while the bus clock is high), the next byte is taken as a control byte. After a stop condition (data rising while the bus clock is high), the block stays silent and acknowledges nothing until the next start.
- R2: The control byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 set to 1 selects a read and 0 selects a write. Any other control byte gets no acknowledge, and the block goes silent.
- R3: An acknowledge pulls the data line low for the whole ninth bus clock of the byte. `sda_oe_o` never changes while the bus clock stays high, and it is low again once the ninth clock has ended.
- R4: On a write, the two bytes that follow the control byte are the word address: high byte first, each byte sent most significant bit first. Both bytes are acknowledged. The pointer becomes {high[4:0], low}, so the top three bits of the high byte are ignored.
- R5: Each write data byte is acknowledged and produces a one-cycle `wr_valid_o` with the byte on `wr_data_o` and the current pointer on `mem_addr_o`. The pointer then increments modulo 8192.
- R6: A stop condition that closes a transfer in which at least one data byte was written produces exactly one one-cycle `commit_o`.
- R7: If `busy_i` is high in the cycle the control byte completes, the control byte is not acknowledged. `busy_i` has no effect on address or data bytes, nor on an acknowledge already decided.
- R8: On a read, the byte at the pointer is requested with a one-cycle `rd_req_o` and shifted out most significant bit first. The pointer increments after each byte. A master acknowledge fetches the next byte. A master non-acknowledge ends the read with the data line released.
- R9: A repeated start returns the block to control-byte reception and keeps the pointer, so a write header followed by a repeated start and a read control byte reads from the address just written.
- R10: After reset, `sda_oe_o`, `wr_valid_o`, `rd_req_o` and `commit_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Select strap; matched against control byte bits 3..1 |
| busy_i | input | 1 | Storage write cycle in progress |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_data_o | output | 8 | Received data byte |
| mem_addr_o | output | 13 | Address for the write strobe or read request |
| rd_req_o | output | 1 | One-cycle read request to the memory port |
| rd_data_i | input | 8 | Read data, valid two edges after the request edge |
| commit_o | output | 1 | One-cycle strobe at a stop that closes a write |

## Verification
The busy check and the acknowledge decision meet in one cycle: the cycle in which the bus clock's fall after the eighth bit of the control byte is seen. The bench provokes this in two ways. It drops `busy_i` one system clock after that fall, which is before the decision, and expects an acknowledge. It raises `busy_i` a few clocks after the fall, which is after the decision, and expects the acknowledge to be held and the following address and data bytes to be accepted. Both cases are judged by sampling the wired data line in the middle of the ninth bus clock, and by the write strobes that the scoreboard expects.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] BIT_MACK = 4'd9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } tws_state_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_c,
  output logic stop_c
);
  logic scl_m, scl_s, scl_q;
  logic sda_m, sda_s, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      {scl_m, scl_s, scl_q} <= 3'b111;
      {sda_m, sda_s, sda_q} <= 3'b111;
    end else begin
      scl_m <= scl_i;
      scl_s <= scl_m;
      scl_q <= scl_s;
      sda_m <= sda_i;
      sda_s <= sda_m;
      sda_q <= sda_s;
    end
  end

  assign scl_lvl  = scl_s;
  assign sda_lvl  = sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int SEL_W = 3,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              rd_req_o,
  output logic              commit_o
);
  localparam int HI_W = ADDR_W - BYTE_W;

  tws_state_t        st, nxt;
  logic [3:0]        bitcnt;
  logic              in_ack;
  logic [BYTE_W-1:0] sh, tx;
  logic [1:0]        pend;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0]   hi;
  logic              wrote;
  logic              ctl_ok, dec_rx;

  assign ctl_ok = (sh[7:4] == DEV_CODE) && (sh[3:1] == strap_i) && !busy_i;
  assign dec_rx = (st != ST_IDLE) && (st != ST_RDAT) && scl_fall && !in_ack && (bitcnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; nxt <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0;
      sh <= '0; tx <= '0; pend <= '0; ptr <= '0; hi <= '0; wrote <= 1'b0;
      sda_oe_o <= 1'b0; wr_valid_o <= 1'b0; wr_data_o <= '0;
      mem_addr_o <= '0; rd_req_o <= 1'b0; commit_o <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_req_o   <= 1'b0;
      commit_o   <= 1'b0;
      pend       <= {pend[0], 1'b0};
      if (pend[1]) tx <= rd_data_i;

      if (stop_c) begin
        st <= ST_IDLE; in_ack <= 1'b0; sda_oe_o <= 1'b0;
        commit_o <= wrote; wrote <= 1'b0;
      end else if (start_c) begin
        st <= ST_CTRL; bitcnt <= '0; in_ack <= 1'b0; sda_oe_o <= 1'b0;
      end else if (st == ST_RDAT) begin
        if (scl_rise) begin
          if (bitcnt < BIT_LAST) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == BIT_LAST) begin
            ptr <= ptr + 1'b1;
            if (!sda_lvl) begin
              rd_req_o <= 1'b1; mem_addr_o <= ptr + 1'b1;
              pend <= 2'b01; bitcnt <= BIT_MACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == BIT_LAST) begin
            sda_oe_o <= 1'b0;
          end else if (bitcnt == BIT_MACK) begin
            sda_oe_o <= ~tx[7]; bitcnt <= '0;
          end else if (bitcnt != 4'd0) begin
            tx <= {tx[6:0], 1'b0}; sda_oe_o <= ~tx[6];
          end
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise && bitcnt < BIT_LAST) begin
          sh <= {sh[6:0], sda_lvl};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && in_ack) begin
          in_ack <= 1'b0; bitcnt <= '0; st <= nxt;
          sda_oe_o <= (nxt == ST_RDAT) ? ~tx[7] : 1'b0;
        end else if (dec_rx) begin
          in_ack <= 1'b1;
          case (st)
            ST_CTRL: begin
              if (ctl_ok) begin
                sda_oe_o <= 1'b1;
                if (sh[0]) begin
                  nxt <= ST_RDAT; rd_req_o <= 1'b1; mem_addr_o <= ptr; pend <= 2'b01;
                end else begin
                  nxt <= ST_AHI;
                end
              end else begin
                st <= ST_IDLE;
              end
            end
            ST_AHI: begin
              sda_oe_o <= 1'b1; hi <= sh[HI_W-1:0]; nxt <= ST_ALO;
            end
            ST_ALO: begin
              sda_oe_o <= 1'b1; ptr <= {hi, sh}; nxt <= ST_WDAT;
            end
            default: begin
              sda_oe_o <= 1'b1; wr_valid_o <= 1'b1; wr_data_o <= sh;
              mem_addr_o <= ptr; ptr <= ptr + 1'b1; wrote <= 1'b1; nxt <= ST_WDAT;
            end
          endcase
        end
      end
    end
  end

  // R3: the enable never moves while the bus clock stays high
  p_oe_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && !scl_rise) |-> $stable(sda_oe_o));
  // R5: write, read and commit strobes never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_valid_o, rd_req_o, commit_o}));
  // R7: a control byte completing under busy leaves the line released
  p_busy_noack_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_rx && st == ST_CTRL && busy_i) |=> !sda_oe_o);
  // R8: read requests are single-cycle pulses
  p_rdreq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o);
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int SEL_W = 3,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              commit_o
);
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_c, stop_c;

  tws_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_c(start_c), .stop_c(stop_c)
  );

  tws_engine #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_eng (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_lvl(sda_lvl), .start_c(start_c), .stop_c(stop_c),
    .strap_i(strap_i), .busy_i(busy_i), .rd_data_i(rd_data_i),
    .sda_oe_o(sda_oe_o), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .mem_addr_o(mem_addr_o), .rd_req_o(rd_req_o), .commit_o(commit_o)
  );
endmodule

// File: tb/tws_mem_slave_tb.sv
module tws_mem_slave_tb;
  localparam int QP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic busy = 1'b0;
  logic sda_oe, wr_valid, rd_req, commit;
  logic [7:0] wr_data, rd_data;
  logic [12:0] mem_addr;
  logic sda_line;

  int errors = 0;
  int checks = 0;
  int commits = 0;
  logic [20:0] exp_q[$];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tws_mem_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .busy_i(busy), .sda_oe_o(sda_oe), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .mem_addr_o(mem_addr), .rd_req_o(rd_req), .rd_data_i(rd_data), .commit_o(commit)
  );

  function automatic logic [7:0] mem_fn(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b011};
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= mem_fn(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes and commits
  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected write", {mem_addr, wr_data}, 0);
      else begin
        logic [20:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, wr_data} == e, "R5 write addr/data", {mem_addr, wr_data}, e);
      end
    end
    if (!rst && commit) commits++;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(QP); scl = 1'b1; w(QP); sda_m = 1'b0; w(QP); scl = 1'b0; w(QP);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(QP); scl = 1'b1; w(QP); sda_m = 1'b1; w(QP);
  endtask

  // mode 1: drop busy one clock after the last bit's fall; mode 2: raise busy after the decision
  task automatic send_byte(input logic [7:0] b, input int mode, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(QP); scl = 1'b1; w(2*QP); scl = 1'b0;
      if (i == 0 && mode == 1) begin w(1); busy = 1'b0; w(QP-1); end
      else if (i == 0 && mode == 2) begin w(6); busy = 1'b1; w(QP-6); end
      else w(QP);
    end
    sda_m = 1'b1; w(QP); scl = 1'b1; w(QP); ack = !sda_line; w(QP); scl = 1'b0; w(QP);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(QP); scl = 1'b1; w(QP); b[i] = sda_line; w(QP); scl = 1'b0; w(QP);
    end
    sda_m = !mack; w(QP); scl = 1'b1; w(2*QP); scl = 1'b0; w(QP); sda_m = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    bit a;
    logic [7:0] d;
    w(5); rst = 1'b0; w(2);
    chk(!sda_oe && !wr_valid && !rd_req && !commit, "R10 reset outputs",
        {sda_oe, wr_valid, rd_req, commit}, 0);

    // R2: wrong strap, wrong device code
    bus_start(); send_byte(8'hA6, 0, a); chk(!a, "R2 strap mismatch nack", a, 0); bus_stop();
    bus_start(); send_byte(8'hBA, 0, a); chk(!a, "R2 code mismatch nack", a, 0); bus_stop();

    // R1 R3 R4 R5 R6: plain write of three bytes
    bus_start(); send_byte(8'hAA, 0, a); chk(a, "R2 control ack", a, 1);
    send_byte(8'h01, 0, a); chk(a, "R4 high address ack", a, 1);
    send_byte(8'h20, 0, a); chk(a, "R4 low address ack", a, 1);
    exp_q.push_back({13'h0120, 8'h11}); exp_q.push_back({13'h0121, 8'h22});
    exp_q.push_back({13'h0122, 8'h33});
    send_byte(8'h11, 0, a); chk(a, "R5 data ack", a, 1);
    chk(!sda_oe, "R3 released after ninth clock", sda_oe, 0);
    send_byte(8'h22, 0, a); send_byte(8'h33, 0, a);
    bus_stop(); w(4);
    chk(commits == 1, "R6 commit after write", commits, 1);

    // R1: bytes without a start after stop are ignored
    send_byte(8'hAA, 0, a); chk(!a, "R1 silent after stop", a, 0); bus_stop(); w(4);
    chk(commits == 1, "R6 no commit without data", commits, 1);

    // R4: upper three address bits ignored
    bus_start(); send_byte(8'hAA, 0, a); send_byte(8'hFF, 0, a);
    chk(a, "R4 ack despite upper bits", a, 1);
    send_byte(8'h10, 0, a);
    exp_q.push_back({13'h1F10, 8'h5A}); send_byte(8'h5A, 0, a); bus_stop();

    // R5: pointer wraps at the top of the space
    bus_start(); send_byte(8'hAA, 0, a); send_byte(8'h1F, 0, a); send_byte(8'hFF, 0, a);
    exp_q.push_back({13'h1FFF, 8'h77}); exp_q.push_back({13'h0000, 8'h88});
    send_byte(8'h77, 0, a); send_byte(8'h88, 0, a); bus_stop(); w(4);
    chk(commits == 3, "R6 commit count", commits, 3);

    // R7: busy blocks the control byte
    busy = 1'b1;
    bus_start(); send_byte(8'hAA, 0, a); chk(!a, "R7 busy nack", a, 0); bus_stop();

    // R7 same-cycle: busy drops just before the decision
    bus_start(); send_byte(8'hAA, 1, a); chk(a, "R7 busy dropped before decision", a, 1);
    bus_stop();
    // R7 same-cycle: busy rises just after the decision, ack held, data accepted
    bus_start(); send_byte(8'hAA, 2, a); chk(a, "R7 busy after decision keeps ack", a, 1);
    send_byte(8'h00, 0, a); send_byte(8'h05, 0, a); chk(a, "R7 address ack under busy", a, 1);
    exp_q.push_back({13'h0005, 8'hC3}); send_byte(8'hC3, 0, a);
    chk(a, "R7 data ack under busy", a, 1);
    bus_stop(); busy = 1'b0;

    // R8 R9: set address, repeated start, sequential read
    bus_start(); send_byte(8'hAA, 0, a); send_byte(8'h02, 0, a); send_byte(8'h40, 0, a);
    bus_start(); send_byte(8'hAB, 0, a); chk(a, "R9 read control ack after repeated start", a, 1);
    recv_byte(d, 1'b1); chk(d == mem_fn(13'h0240), "R9 first byte at kept pointer", d, mem_fn(13'h0240));
    recv_byte(d, 1'b1); chk(d == mem_fn(13'h0241), "R8 second byte", d, mem_fn(13'h0241));
    recv_byte(d, 1'b0); chk(d == mem_fn(13'h0242), "R8 last byte", d, mem_fn(13'h0242));
    chk(!sda_oe, "R8 released after nack", sda_oe, 0);
    bus_stop(); w(4);
    chk(commits == 4, "R6 no commit on header-only write", commits, 4);

    // R8: a new read continues after the last byte read
    bus_start(); send_byte(8'hAB, 0, a);
    recv_byte(d, 1'b0); chk(d == mem_fn(13'h0243), "R8 pointer continues", d, mem_fn(13'h0243));
    bus_stop(); w(10);

    chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule